// File: doc/BRIEF.md
# Serial Flash Full-Erase Sequencer

This block is a host-side SPI master that erases a whole serial flash device in response to a single start pulse. It runs three chip-select frames in sequence. The first frame carries the write-enable opcode. The second carries the full-erase opcode, and raising chip-select at its end starts the erase inside the device. The third frame carries the read-status opcode and then keeps clocking, so that status bytes stream back without the command being issued again.

Bit 0 of each returned status byte is the device's busy indication. When a byte arrives with that bit clear, the sequencer closes the frame and pulses `done`. If the device stays busy for a parameterised number of status bytes, the sequencer closes the frame, raises `err` and goes idle. SCK runs in mode 0 at the system clock divided by 2·`DIV`. Chip-select is held high for at least `GAP` SCK half-periods before every frame.

Top module: `flash_erase_seq`

## Requirements
- R1: After reset, `cs_n` is 1, `sck` is 0, and `done`, `err` and `running` are 0.
- R2: The first frame after a start holds exactly 8 SCK rising edges and carries opcode 0x06, MSB first. `cs_n` then returns high.
- R3: The second frame holds exactly 8 SCK rising edges and carries opcode 0x60, MSB first. `cs_n` then returns high.
- R4: The third frame opens with opcode 0x05. It then stays low for a continuous run of status bytes, each 8 SCK cycles long, with no further opcode sent.
- R5: SCK is low whenever `cs_n` is high. `mosi` never changes while `sck` stays high during a frame. `miso` is sampled on SCK rising edges, MSB first.
- R6: Before each frame, `cs_n` is high for at least `GAP*DIV` system clock cycles.
- R7: When a status byte arrives with bit 0 equal to 0, `cs_n` rises at the end of that byte and `done` is high for exactly one cycle in the same cycle. `err` stays 0.
- R8: Bits 7 to 1 of the status bytes have no effect on when the sequence ends.
- R9: If `MAX_POLLS` consecutive status bytes all have bit 0 equal to 1, the frame ends after the last of them. `err` then becomes 1, `done` is not pulsed, and the block returns to idle.
- R10: `err` stays 1 while the block is idle, and the next accepted start clears it on the following cycle.
- R11: A start pulse while `running` is 1 is ignored. The sequence in progress keeps its three frames and gives a single completion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle request to begin a full erase |
| running | output | 1 | High while a sequence is in progress |
| done | output | 1 | One-cycle pulse when the device reports not busy |
| err | output | 1 | Timeout flag, held until the next start |
| cs_n | output | 1 | Active-low chip-select to the flash |
| sck | output | 1 | Serial clock, idle low |
| mosi | output | 1 | Serial data to the flash |
| miso | input | 1 | Serial data from the flash |

## Verification
The in-module assertions check the SPI line discipline on every cycle: SCK stays low while deselected, MOSI holds steady through every high SCK phase, and chip-select stays high for the minimum gap before each frame. They also check that `done` lasts one cycle, coincides with deselection and never occurs together with `err`. Opcode contents, frame lengths, the length of the status stream, the point where busy clears or the timeout fires, and the disregard of the upper status bits only become visible through the bench's flash model. That model counts bits per frame and returns scripted status sequences.

// File: rtl/flash_erase_seq.sv
module flash_erase_seq #(
  parameter int DIV       = 4,
  parameter int GAP       = 2,
  parameter int MAX_POLLS = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic running,
  output logic done,
  output logic err,
  output logic cs_n,
  output logic sck,
  output logic mosi,
  input  logic miso
);

  localparam int CW       = $clog2(DIV + 1);
  localparam int GW       = $clog2(GAP + 1);
  localparam int PW       = $clog2(MAX_POLLS + 1);
  localparam int GAP_CLKS = GAP * DIV;
  localparam int HW       = $clog2(GAP_CLKS + 1) + 1;

  typedef enum logic [1:0] {S_IDLE, S_GAP, S_XFER} st_t;
  typedef enum logic [1:0] {PH_WEN, PH_ERASE, PH_POLL} ph_t;

  st_t          st;
  ph_t          ph;
  logic [CW-1:0] cnt;
  logic [GW-1:0] gcnt;
  logic [PW-1:0] polls;
  logic [2:0]    bcnt;
  logic [7:0]    txr, rxr;
  logic          hdr;
  logic          tick;

  assign tick    = (st != S_IDLE) && (cnt == CW'(DIV - 1));
  assign running = (st != S_IDLE);
  assign mosi    = txr[7];

  function automatic logic [7:0] opcode(ph_t p);
    case (p)
      PH_WEN:   return 8'h06;
      PH_ERASE: return 8'h60;
      default:  return 8'h05;
    endcase
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= S_IDLE;
      ph    <= PH_WEN;
      cnt   <= '0;
      gcnt  <= '0;
      polls <= '0;
      bcnt  <= '0;
      txr   <= '0;
      rxr   <= '0;
      hdr   <= 1'b0;
      sck   <= 1'b0;
      cs_n  <= 1'b1;
      done  <= 1'b0;
      err   <= 1'b0;
    end else begin
      done <= 1'b0;
      if (st == S_IDLE) cnt <= '0;
      else cnt <= tick ? '0 : cnt + 1'b1;

      case (st)
        S_IDLE: if (start) begin
          st    <= S_GAP;
          ph    <= PH_WEN;
          gcnt  <= '0;
          polls <= '0;
          err   <= 1'b0;
          cs_n  <= 1'b1;
        end
        S_GAP: if (tick) begin
          if (gcnt == GW'(GAP - 1)) begin
            st   <= S_XFER;
            cs_n <= 1'b0;
            sck  <= 1'b0;
            bcnt <= '0;
            txr  <= opcode(ph);
            hdr  <= 1'b1;
          end else begin
            gcnt <= gcnt + 1'b1;
          end
        end
        S_XFER: if (tick) begin
          if (!sck) begin
            sck <= 1'b1;
            rxr <= {rxr[6:0], miso};
          end else begin
            sck  <= 1'b0;
            bcnt <= bcnt + 1'b1;
            txr  <= {txr[6:0], 1'b0};
            if (bcnt == 3'd7) begin
              if (ph != PH_POLL) begin
                cs_n <= 1'b1;
                st   <= S_GAP;
                gcnt <= '0;
                ph   <= (ph == PH_WEN) ? PH_ERASE : PH_POLL;
              end else if (hdr) begin
                hdr <= 1'b0;
              end else if (!rxr[0]) begin
                cs_n <= 1'b1;
                st   <= S_IDLE;
                done <= 1'b1;
              end else if (polls == PW'(MAX_POLLS - 1)) begin
                cs_n <= 1'b1;
                st   <= S_IDLE;
                err  <= 1'b1;
              end else begin
                polls <= polls + 1'b1;
              end
            end
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  logic [HW-1:0] hicnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hicnt <= '0;
    else if (!cs_n) hicnt <= '0;
    else if (hicnt != {HW{1'b1}}) hicnt <= hicnt + 1'b1;
  end

  p_sck_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !sck);
  p_mosi_stable_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && sck && $past(sck) && !$past(cs_n)) |-> $stable(mosi));
  p_gap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cs_n) |-> (hicnt >= HW'(GAP_CLKS)));
  p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_done_cs_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (cs_n && !running));
  p_err_nodone_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !err);

endmodule

// File: tb/flash_erase_seq_bench.sv
module flash_erase_seq_bench;
  localparam int DIV  = 2;
  localparam int GAP  = 3;
  localparam int MAXP = 5;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, miso = 1'b0;
  logic running, done, err, cs_n, sck, mosi;

  always #10 clk = ~clk;

  flash_erase_seq #(.DIV(DIV), .GAP(GAP), .MAX_POLLS(MAXP)) u_flash_erase_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .running(running), .done(done),
    .err(err), .cs_n(cs_n), .sck(sck), .mosi(mosi), .miso(miso));

  int nchk = 0, nfail = 0, cyc = 0;

  // flash model state
  int nfr = 0, curbits = 0;
  logic [7:0] sh;
  logic [7:0] ops [8];
  int bits [8];
  int busy_n;
  logic [7:0] bval, fval;
  int hirun = 0, mingap = 1000000;

  always @(negedge cs_n) curbits = 0;
  always @(posedge cs_n) begin
    if (nfr < 8) bits[nfr] = curbits;
    nfr++;
  end
  always @(posedge sck) if (!cs_n) begin
    sh = {sh[6:0], mosi};
    curbits++;
    if (curbits == 8 && nfr < 8) ops[nfr] = sh;
  end
  always @(negedge sck) if (!cs_n && curbits >= 8 && nfr < 8 && ops[nfr] == 8'h05) begin
    int k;
    logic [7:0] sb;
    k  = curbits / 8 - 1;
    sb = (k < busy_n) ? bval : fval;
    miso = sb[7 - (curbits % 8)];
  end
  always @(posedge clk) begin
    if (cs_n) hirun++;
    else begin
      if (hirun != 0 && hirun < mingap) mingap = hirun;
      hirun = 0;
    end
  end

  task automatic chk(string req, int act, int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      nfail++;
      $display("FAIL watchdog actual=%0d expected=0", cyc);
      finish_run();
    end
  end

  // busy bytes, busy value, free value
  localparam logic [23:0] VEC [6] = '{
    {8'd0, 8'h03, 8'h02},
    {8'd1, 8'h01, 8'h00},
    {8'd3, 8'hFF, 8'hFE},
    {8'd4, 8'h03, 8'h02},
    {8'd5, 8'h03, 8'h02},
    {8'd9, 8'h81, 8'h7E}
  };

  int ndone;

  task automatic run(int bn, logic [7:0] bv, logic [7:0] fv, bit restart_mid);
    bit prev_err;
    int nbytes;
    bit exp_err;
    busy_n = bn; bval = bv; fval = fv;
    nfr = 0; mingap = 1000000; ndone = 0;
    prev_err = err;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    if (prev_err) chk("R10 err cleared by start", err, 0);
    chk("R11 running after start", running, 1);
    for (int i = 0; i < 20000; i++) begin
      if (restart_mid && i == 100) start = 1'b1;
      if (restart_mid && i == 101) start = 1'b0;
      if (done) ndone++;
      if (!running) break;
      @(negedge clk);
    end
    chk("R9 sequence ends", running, 0);
    exp_err = (bn >= MAXP);
    nbytes  = exp_err ? MAXP : bn + 1;
    chk("R9 err level", err, exp_err);
    chk("R7 done pulses", ndone, exp_err ? 0 : 1);
    chk("R11 frame count", nfr, 3);
    chk("R2 wren opcode", ops[0], 8'h06);
    chk("R2 wren bits", bits[0], 8);
    chk("R3 erase opcode", ops[1], 8'h60);
    chk("R3 erase bits", bits[1], 8);
    chk("R4 status opcode", ops[2], 8'h05);
    chk("R4 R8 status frame bits", bits[2], 8 * (1 + nbytes));
    chk("R6 min gap", (mingap >= GAP * DIV) ? 1 : 0, 1);
    repeat (5) @(negedge clk);
    chk("R10 err held idle", err, exp_err);
    chk("R5 sck idle", sck, 0);
  endtask

  initial begin
    busy_n = 0; bval = 8'h03; fval = 8'h02;
    repeat (3) @(negedge clk);
    chk("R1 cs_n reset", cs_n, 1);
    chk("R1 sck reset", sck, 0);
    chk("R1 done reset", done, 0);
    chk("R1 err reset", err, 0);
    chk("R1 running reset", running, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    for (int v = 0; v < 6; v++)
      run(int'(VEC[v][23:16]), VEC[v][15:8], VEC[v][7:0], 1'b0);
    // R10: previous run ended in err; this one clears it
    run(2, 8'h03, 8'h02, 1'b1);
    // R8: upper bits set in the free byte still end the poll
    run(0, 8'h01, 8'hFE, 1'b0);
    // boundary: busy exactly until the timeout limit
    run(MAXP - 1, 8'h01, 8'h00, 1'b0);
    run(MAXP, 8'h01, 8'h00, 1'b0);
    finish_run();
  end
endmodule